// File: doc/BRIEF.md
# Interrupt Status, Enable and Mask Aggregator

This block gathers single-cycle event pulses from the transmit and receive logic of a bus controller. It also takes one level condition, "receive frames pending". It keeps them in a 32-bit sticky status register. One level-sensitive interrupt line is raised whenever a latched status bit is also enabled. Software controls the block through a simple word-addressed write/read strobe.

Two registers shape the behaviour, and they act at different points. The mask acts at the input: a masked event is never recorded and is not held for later. The enable acts at the output: it only decides whether a recorded bit drives the interrupt line. Each of the two registers has a separate set address and a separate clear address, so no read-modify-write is needed. Status bits are cleared by writing ones to them.

Top module: `intc_evt_aggregator`

## Requirements
- R1: A write to the status address (word address 0) clears each status bit whose written bit is one and leaves every bit written as zero unchanged.
- R2: A write to address 1 ORs the written value into the enable register. A write to address 2 clears the enable bits written as one. Nothing else changes the enable register.
- R3: The mask register follows the same scheme: address 3 sets bits and address 4 clears bits.
- R4: An event whose mask bit is one at the clock edge is not latched. Clearing that mask bit later does not make the lost event appear.
- R5: Once latched, a status bit stays set until software clears it. Event bits are: 0 receive done, 1 transmit done, 2 buffer state change, 3 overrun, 4 FIFO full, 5 receive frames pending. Bits 6 to 31 never set.
- R6: The interrupt output is a register that holds the OR of (status AND enable) as it stood one clock earlier.
- R7: With the read strobe high, addresses 1 and 2 both return the enable register, and addresses 3 and 4 both return the mask register. Address 0 returns status. Any other address, or a low read strobe, returns zero.
- R8: While the frames-pending input is high and bit 5 is unmasked, bit 5 is latched on every clock, so clearing it has no lasting effect.
- R9: When an unmasked event and a status clear of the same bit meet in one cycle, the bit ends up set.
- R10: Reset clears status, enable and mask and holds the interrupt output low.
- R11: Writes to addresses 5 to 7 change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | 3 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| evt_pulse_i | input | 5 | Event pulses, bits 0 to 4 of status |
| rx_pend_i | input | 1 | Receive frames pending level, bit 5 of status |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
On every cycle the assertions check four things. The interrupt output tracks the previous cycle's status and enable product. A newly set status bit must come from an unmasked event. An unmasked event always lands in status. Enable and mask set/clear writes take effect on the next edge. Only the bench's scenarios can show the following: lost masked events stay lost after unmasking, the read aliasing and zeroes at unmapped addresses, ignored writes to unmapped addresses, and how the frames-pending bit behaves against repeated clears. These depend on sequences of writes and reads at the bus interface.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int DATA_W    = 32;
    localparam int NUM_PULSE = 5;
    localparam int PEND_BIT  = NUM_PULSE;

    typedef enum logic [2:0] {
        ADR_STATUS   = 3'd0,
        ADR_EN_SET   = 3'd1,
        ADR_EN_CLR   = 3'd2,
        ADR_MSK_SET  = 3'd3,
        ADR_MSK_CLR  = 3'd4
    } intc_addr_e;

    typedef struct packed {
        logic sts_w1c;
        logic en_set;
        logic en_clr;
        logic msk_set;
        logic msk_clr;
    } intc_wr_dec_t;

endpackage

// File: rtl/intc_setclr_reg.sv
module intc_setclr_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] val;
    } reg_state_t;

    reg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_we) st_d.val = st_d.val | wdata;
        if (clr_we) st_d.val = st_d.val & ~wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.val;
endmodule

// File: rtl/intc_status_reg.sv
module intc_status_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic [W-1:0] mask,
    input  logic         w1c_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] sts;
    } sts_state_t;

    sts_state_t st_d, st_q;
    logic [W-1:0] clr_bits;
    logic [W-1:0] new_bits;

    always_comb begin
        clr_bits = w1c_we ? wdata : '0;
        new_bits = evt & ~mask;
        st_d     = st_q;
        // clear first, then new events override a clear of the same bit
        st_d.sts = (st_q.sts & ~clr_bits) | new_bits;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.sts;
endmodule

// File: rtl/intc_read_mux.sv
module intc_read_mux
    import intc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         rd,
    input  logic [2:0]   addr,
    input  logic [W-1:0] sts,
    input  logic [W-1:0] en,
    input  logic [W-1:0] msk,
    output logic [W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        if (rd) begin
            case (addr)
                ADR_STATUS:               rdata = sts;
                ADR_EN_SET, ADR_EN_CLR:   rdata = en;
                ADR_MSK_SET, ADR_MSK_CLR: rdata = msk;
                default:                  rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/intc_evt_aggregator.sv
module intc_evt_aggregator
    import intc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr_i,
    input  logic                 bus_rd_i,
    input  logic [2:0]           bus_addr_i,
    input  logic [DATA_W-1:0]    bus_wdata_i,
    output logic [DATA_W-1:0]    bus_rdata_o,
    input  logic [NUM_PULSE-1:0] evt_pulse_i,
    input  logic                 rx_pend_i,
    output logic                 irq_o
);
    localparam int PAD_W = DATA_W - NUM_PULSE - 1;

    typedef struct packed {
        logic irq;
    } top_state_t;

    intc_wr_dec_t      dec;
    logic [DATA_W-1:0] evt_vec;
    logic [DATA_W-1:0] status_q;
    logic [DATA_W-1:0] enable_q;
    logic [DATA_W-1:0] mask_q;
    top_state_t        st_d, st_q;

    always_comb begin
        dec         = '0;
        dec.sts_w1c = bus_wr_i && (bus_addr_i == ADR_STATUS);
        dec.en_set  = bus_wr_i && (bus_addr_i == ADR_EN_SET);
        dec.en_clr  = bus_wr_i && (bus_addr_i == ADR_EN_CLR);
        dec.msk_set = bus_wr_i && (bus_addr_i == ADR_MSK_SET);
        dec.msk_clr = bus_wr_i && (bus_addr_i == ADR_MSK_CLR);
    end

    generate
        if (PAD_W > 0) begin : g_pad
            assign evt_vec = {{PAD_W{1'b0}}, rx_pend_i, evt_pulse_i};
        end else begin : g_nopad
            assign evt_vec = {rx_pend_i, evt_pulse_i};
        end
    endgenerate

    intc_status_reg #(.W(DATA_W)) u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (evt_vec),
        .mask   (mask_q),
        .w1c_we (dec.sts_w1c),
        .wdata  (bus_wdata_i),
        .q      (status_q)
    );

    intc_setclr_reg #(.W(DATA_W)) u_enable (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_we (dec.en_set),
        .clr_we (dec.en_clr),
        .wdata  (bus_wdata_i),
        .q      (enable_q)
    );

    intc_setclr_reg #(.W(DATA_W)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_we (dec.msk_set),
        .clr_we (dec.msk_clr),
        .wdata  (bus_wdata_i),
        .q      (mask_q)
    );

    intc_read_mux #(.W(DATA_W)) u_rmux (
        .rd    (bus_rd_i),
        .addr  (bus_addr_i),
        .sts   (status_q),
        .en    (enable_q),
        .msk   (mask_q),
        .rdata (bus_rdata_o)
    );

    always_comb begin
        st_d     = st_q;
        st_d.irq = |(status_q & enable_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.irq;
endmodule

// File: rtl/intc_evt_aggregator_chk.sv
module intc_evt_aggregator_chk
    import intc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr_i,
    input logic [2:0]        bus_addr_i,
    input logic [DATA_W-1:0] bus_wdata_i,
    input logic [DATA_W-1:0] evt_vec,
    input logic [DATA_W-1:0] status_q,
    input logic [DATA_W-1:0] enable_q,
    input logic [DATA_W-1:0] mask_q,
    input logic              irq_o
);
    AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(|(status_q & enable_q)))); // R6

    AST_MASKED_NOT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & ~$past(status_q) & $past(mask_q)) == '0)); // R4

    AST_UNMASKED_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(evt_vec) & ~$past(mask_q) & ~status_q) == '0)); // R9

    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & ~$past(status_q) & ~$past(evt_vec)) == '0)); // R5

    AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == ADR_EN_SET)
        |=> ((enable_q & $past(bus_wdata_i)) == $past(bus_wdata_i))); // R2

    AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == ADR_EN_CLR)
        |=> ((enable_q & $past(bus_wdata_i)) == '0)); // R2

    AST_MSK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == ADR_MSK_SET)
        |=> ((mask_q & $past(bus_wdata_i)) == $past(bus_wdata_i))); // R3

    AST_MSK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == ADR_MSK_CLR)
        |=> ((mask_q & $past(bus_wdata_i)) == '0)); // R3
endmodule

bind intc_evt_aggregator intc_evt_aggregator_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .evt_vec     (evt_vec),
    .status_q    (status_q),
    .enable_q    (enable_q),
    .mask_q      (mask_q),
    .irq_o       (irq_o)
);

// File: tb/intc_evt_aggregator_tb.sv
module intc_evt_aggregator_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_i = 1'b0;
    logic        bus_rd_i = 1'b0;
    logic [2:0]  bus_addr_i = '0;
    logic [31:0] bus_wdata_i = '0;
    logic [31:0] bus_rdata_o;
    logic [4:0]  evt_pulse_i = '0;
    logic        rx_pend_i = 1'b0;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] m_sts = '0, m_en = '0, m_msk = '0;
    logic        m_irq = 1'b0;

    always #10 clk = ~clk;

    intc_evt_aggregator u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr_i), .bus_rd_i(bus_rd_i),
        .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
        .bus_rdata_o(bus_rdata_o), .evt_pulse_i(evt_pulse_i),
        .rx_pend_i(rx_pend_i), .irq_o(irq_o)
    );

    function automatic logic [31:0] exp_read(input logic [2:0] a);
        case (a)
            3'd0:       return m_sts;
            3'd1, 3'd2: return m_en;
            3'd3, 3'd4: return m_msk;
            default:    return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] next_sts(input logic wr, input logic [2:0] a,
            input logic [31:0] wd, input logic [4:0] ev, input logic pend);
        logic [31:0] clr;
        logic [31:0] evv;
        clr = (wr && a == 3'd0) ? wd : 32'h0;
        evv = {26'h0, pend, ev};
        return (m_sts & ~clr) | (evv & ~m_msk);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one clock: drive at negedge, model at posedge, inputs released at next negedge
    task automatic step(input logic wr, input logic [2:0] a, input logic [31:0] wd,
                        input logic [4:0] ev, input logic pend);
        logic [31:0] ns;
        logic        ni;
        bus_wr_i = wr; bus_addr_i = a; bus_wdata_i = wd;
        evt_pulse_i = ev; rx_pend_i = pend;
        @(posedge clk);
        ni = |(m_sts & m_en);
        ns = next_sts(wr, a, wd, ev, pend);
        if (wr && a == 3'd1) m_en  = m_en | wd;
        if (wr && a == 3'd2) m_en  = m_en & ~wd;
        if (wr && a == 3'd3) m_msk = m_msk | wd;
        if (wr && a == 3'd4) m_msk = m_msk & ~wd;
        m_sts = ns;
        m_irq = ni;
        @(negedge clk);
        bus_wr_i = 1'b0; evt_pulse_i = '0; rx_pend_i = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a);
        bus_rd_i = 1'b1; bus_addr_i = a;
        #1;
        check(req, bus_rdata_o, exp_read(a));
        bus_rd_i = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 3'd0, 32'h0, 5'h0, 1'b0);
    endtask

    initial begin
        #(20 * 20000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 irq", {31'h0, irq_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        rd_chk("R10 status", 3'd0);
        rd_chk("R10 enable", 3'd1);
        rd_chk("R10 mask", 3'd3);

        // R2/R7: enable set/clear, aliasing at both addresses
        step(1'b1, 3'd1, 32'h0000_00F3, 5'h0, 1'b0);
        rd_chk("R2 enable set", 3'd1);
        rd_chk("R7 enable alias", 3'd2);
        step(1'b1, 3'd2, 32'h0000_0031, 5'h0, 1'b0);
        rd_chk("R2 enable clr", 3'd2);
        check("R2 enable value", exp_read(3'd1), 32'h0000_00C2);

        // R3/R7
        step(1'b1, 3'd3, 32'h0000_000C, 5'h0, 1'b0);
        rd_chk("R3 mask set", 3'd3);
        rd_chk("R7 mask alias", 3'd4);
        step(1'b1, 3'd4, 32'h0000_0004, 5'h0, 1'b0);
        rd_chk("R3 mask clr", 3'd4);

        // R4: masked bit 3 event lost, stays lost after unmask
        step(1'b0, 3'd0, 32'h0, 5'h08, 1'b0);
        rd_chk("R4 masked not latched", 3'd0);
        step(1'b1, 3'd4, 32'h0000_0008, 5'h0, 1'b0);
        rd_chk("R4 not pending after unmask", 3'd0);
        check("R4 status zero", bus_rdata_o, 32'h0);

        // R6: latency; enable bit 1 set, event on bit 1
        step(1'b0, 3'd0, 32'h0, 5'h02, 1'b0);
        check("R6 irq not yet", {31'h0, irq_o}, 32'h0);
        step(1'b0, 3'd0, 32'h0, 5'h0, 1'b0);
        check("R6 irq raised", {31'h0, irq_o}, 32'h1);
        // R5 sticky
        idle(3);
        rd_chk("R5 sticky", 3'd0);
        check("R5 irq held", {31'h0, irq_o}, 32'h1);

        // R1: partial W1C
        step(1'b0, 3'd0, 32'h0, 5'h11, 1'b0);
        step(1'b1, 3'd0, 32'h0000_0012, 5'h0, 1'b0);
        rd_chk("R1 w1c partial", 3'd0);
        check("R1 remaining", exp_read(3'd0), 32'h0000_0001);
        step(1'b0, 3'd0, 32'h0, 5'h0, 1'b0);
        check("R6 irq drops", {31'h0, irq_o}, 32'h0);

        // R9: event and clear of same bit
        step(1'b1, 3'd0, 32'h0000_0001, 5'h01, 1'b0);
        rd_chk("R9 event wins", 3'd0);

        // R8: frames pending relatches
        step(1'b0, 3'd0, 32'h0, 5'h0, 1'b1);
        step(1'b1, 3'd0, 32'h0000_0020, 5'h0, 1'b1);
        rd_chk("R8 pending relatch", 3'd0);
        step(1'b1, 3'd0, 32'h0000_0020, 5'h0, 1'b0);
        rd_chk("R8 cleared when idle", 3'd0);

        // R11: unmapped writes ignored; R7 unmapped read zero
        step(1'b1, 3'd5, 32'hFFFF_FFFF, 5'h0, 1'b0);
        step(1'b1, 3'd7, 32'hFFFF_FFFF, 5'h0, 1'b0);
        rd_chk("R11 status", 3'd0);
        rd_chk("R11 enable", 3'd1);
        rd_chk("R11 mask", 3'd3);
        rd_chk("R7 unmapped", 3'd6);
        bus_addr_i = 3'd0; #1;
        check("R7 no strobe", bus_rdata_o, 32'h0);

        // random phase
        for (int i = 0; i < 1500; i++) begin
            logic        w;
            logic [2:0]  a;
            logic [31:0] d;
            w = ($urandom % 3) == 0;
            a = 3'($urandom % 8);
            d = ($urandom % 5 == 0) ? $urandom : ($urandom & 32'h3F);
            step(w, a, d, 5'($urandom & ($urandom & 32'h1F)), ($urandom % 4) == 0);
            check("R6 irq random", {31'h0, irq_o}, {31'h0, m_irq});
            if (i % 7 == 0) rd_chk("R1 R2 R3 R5 random read", 3'($urandom % 8));
        end

        // R10: reset mid-run
        step(1'b1, 3'd1, 32'hFFFF_FFFF, 5'h1F, 1'b1);
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        m_sts = '0; m_en = '0; m_msk = '0; m_irq = 1'b0;
        check("R10 irq after reset", {31'h0, irq_o}, 32'h0);
        rd_chk("R10 status after reset", 3'd0);
        rd_chk("R10 enable after reset", 3'd2);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule